// File: doc/BRIEF.md
# Trimmed 100 Hz Time-Base Divider

This block turns a stream of oscillator enables at a nominal 32768 Hz into the 100 Hz update strobe that advances a timekeeping core. A free-running crystal tends to run slightly fast. To correct for that, the block counts oscillator enables in fixed windows of 1,015,808 cycles, which is 31 seconds. At the head of each window it drops a programmable number of those enables, so they never reach the divider. One unit of the 8-bit trim value slows the time base by roughly 0.984 ppm. The full value of 255 gives about 251 ppm of correction. The value usually programmed when no tuning is wanted is 210.

The enables that survive drive a fractional divider. This is a phase accumulator that adds a fixed step of 100 for each surviving enable and wraps at 32768. Each wrap gives one strobe, so 32768 survivors yield exactly 100 strobes. A test input turns off all cycle removal. A tuning-mode input drives out a 100 Hz waveform, high for about a fifth of each period, so an external counter can measure the rate.

Top module: `trim_clock_divider`

## Requirements
- R1: Under a synchronous active-high reset, both outputs are low, the window position returns to its start and the phase accumulator is cleared.
- R2: A window is exactly WIN_CYCLES oscillator enables long. Clock cycles with `osc_tick` low do not advance it.
- R3: `trim_val` is sampled on the first enable of each window, giving a count T from 0 to 255. The first T enables of that window are dropped and the rest pass. T = 0 drops none, and T = 255 drops 255.
- R4: While `trim_off` is high, no enable is dropped, whatever the trim value.
- R5: A change of `trim_val` after the first enable of a window has no effect until the next window starts.
- R6: Every passing enable adds ACC_STEP to the phase, modulo ACC_MOD. `tick_100hz` is high in the clock cycle after a passing enable that makes the phase wrap. Over any span, the number of strobes is floor(S1*ACC_STEP/ACC_MOD) - floor(S0*ACC_STEP/ACC_MOD), where S0 and S1 are the cumulative counts of passing enables at the ends of the span.
- R7: `tick_100hz` lasts one clock cycle and only follows a clock cycle in which `osc_tick` was high.
- R8: `tune_wave` is registered. It is high in the cycle after an edge at which `tune_mode` was high and the phase was below ACC_MOD/5. It is low in the cycle after any edge at which `tune_mode` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| trim_val | input | TRIM_W | Count of enables to drop per window |
| trim_off | input | 1 | Test input; high stops all cycle removal |
| tune_mode | input | 1 | Enables the measurement waveform |
| tick_100hz | output | 1 | One-cycle time-update strobe |
| tune_wave | output | 1 | About 20% duty waveform at the strobe rate |

## Verification
The assertions take three things for granted about the parameters and inputs. First, ACC_STEP is below half of ACC_MOD, so two strobes can never be adjacent. Second, 2**TRIM_W is smaller than WIN_CYCLES, so dropped enables stay at the head of a window. Third, `osc_tick` carries at most one enable per clock. The stimulus uses a small window of 300 enables, a modulus of 32 and a step of 4. It walks all 256 trim values, each changed in the middle of the window before it is used, with `osc_tick` either continuous or sparse. A reference model computes every expected strobe and waveform level from the stated arithmetic.

// File: rtl/trim_pkg.sv
package trim_pkg;
  // Duty of the tuning waveform is one part in this many of a phase turn
  localparam int DUTY_DIV = 5;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/trim_swallow_gate.sv
module trim_swallow_gate #(
  parameter int WIN_CYCLES = 1015808,
  parameter int TRIM_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic [TRIM_W-1:0] trim_val,
  input  logic              trim_off,
  output logic              pass_tick
);
  import trim_pkg::*;

  localparam int WIN_W = $clog2(WIN_CYCLES);
  localparam int CMP_W = max_int(WIN_W, TRIM_W) + 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
  localparam logic [CMP_W-1:0] HEAD_MAX = CMP_W'(2 ** TRIM_W);

  logic [WIN_W-1:0]  win_pos;
  logic [TRIM_W-1:0] win_trim;
  logic [TRIM_W-1:0] eff_trim;
  logic              at_head;
  logic              drop;

  // window position and the trim count held for the whole window
  always_ff @(posedge clk) begin
    if (rst) begin
      win_pos  <= '0;
      win_trim <= '0;
    end else if (osc_tick) begin
      win_pos <= (win_pos == WIN_LAST) ? '0 : win_pos + 1'b1;
      if (win_pos == '0) win_trim <= trim_val;
    end
  end

  always_comb begin
    eff_trim  = (win_pos == '0) ? trim_val : win_trim;
    at_head   = CMP_W'(win_pos) < CMP_W'(eff_trim);
    drop      = osc_tick && !trim_off && at_head;
    pass_tick = osc_tick && !drop;
  end

  assert_window_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    $past(osc_tick) && !$past(rst) |->
      win_pos == (($past(win_pos) == WIN_LAST) ? '0 : $past(win_pos) + 1'b1));

  assert_window_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(osc_tick) && !$past(rst) |-> $stable(win_pos));

  assert_drop_in_head_R3: assert property (@(posedge clk) disable iff (rst)
    osc_tick && !pass_tick |-> CMP_W'(win_pos) < HEAD_MAX);

  assert_trim_held_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(win_pos) != '0 |-> $stable(win_trim));
endmodule

// File: rtl/trim_phase_div.sv
module trim_phase_div #(
  parameter int ACC_STEP = 100,
  parameter int ACC_MOD  = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic pass_tick,
  input  logic tune_mode,
  output logic strobe,
  output logic tune_wave
);
  import trim_pkg::*;

  localparam int ACC_W = $clog2(ACC_MOD + ACC_STEP);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(ACC_STEP);
  localparam logic [ACC_W-1:0] MOD_V  = ACC_W'(ACC_MOD);
  localparam logic [ACC_W-1:0] DUTY_V = ACC_W'(ACC_MOD / DUTY_DIV);

  logic [ACC_W-1:0] phase;
  logic [ACC_W-1:0] sum;
  logic             wrap;

  always_comb begin
    sum  = phase + STEP_V;
    wrap = sum >= MOD_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      strobe    <= 1'b0;
      tune_wave <= 1'b0;
    end else begin
      strobe    <= pass_tick && wrap;
      tune_wave <= tune_mode && (phase < DUTY_V);
      if (pass_tick) phase <= wrap ? sum - MOD_V : sum;
    end
  end

  assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
    phase < MOD_V);

  assert_phase_step_R6: assert property (@(posedge clk) disable iff (rst)
    $past(pass_tick) && !$past(rst) |->
      32'(phase) == (32'($past(phase)) + ACC_STEP) % ACC_MOD);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  assert_wave_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(tune_mode) |-> !tune_wave);
endmodule

// File: rtl/trim_clock_divider.sv
module trim_clock_divider #(
  parameter int WIN_CYCLES = 1015808,
  parameter int TRIM_W     = 8,
  parameter int ACC_STEP   = 100,
  parameter int ACC_MOD    = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic [TRIM_W-1:0] trim_val,
  input  logic              trim_off,
  input  logic              tune_mode,
  output logic              tick_100hz,
  output logic              tune_wave
);
  logic pass_tick;

  trim_swallow_gate #(
    .WIN_CYCLES(WIN_CYCLES),
    .TRIM_W    (TRIM_W)
  ) i_gate (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .trim_val (trim_val),
    .trim_off (trim_off),
    .pass_tick(pass_tick)
  );

  trim_phase_div #(
    .ACC_STEP(ACC_STEP),
    .ACC_MOD (ACC_MOD)
  ) i_div (
    .clk      (clk),
    .rst      (rst),
    .pass_tick(pass_tick),
    .tune_mode(tune_mode),
    .strobe   (tick_100hz),
    .tune_wave(tune_wave)
  );

  assert_strobe_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
    tick_100hz |-> $past(osc_tick));

  assert_off_no_drop_R4: assert property (@(posedge clk) disable iff (rst)
    $past(trim_off) && $past(osc_tick) && !$past(rst) && !$past(pass_tick, 1) |-> 1'b0);
endmodule

// File: tb/test_trim_clock_divider.sv
module test_trim_clock_divider;
  localparam int W    = 300;
  localparam int TW   = 8;
  localparam int STEP = 4;
  localparam int MOD  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0;
  logic [TW-1:0] trim_val = '0;
  logic trim_off = 1'b0;
  logic tune_mode = 1'b0;
  logic tick_100hz, tune_wave;

  int total = 0, bad = 0;
  int m_pos = 0, m_lat = 0, m_acc = 0;
  longint cum = 0, win_start = 0;
  int win_obs = 0;
  bit exp_stb = 0, exp_wave = 0;

  always #4 clk = ~clk;

  trim_clock_divider #(.WIN_CYCLES(W), .TRIM_W(TW), .ACC_STEP(STEP), .ACC_MOD(MOD))
    i_trim_clock_divider (.clk(clk), .rst(rst), .osc_tick(osc_tick), .trim_val(trim_val),
      .trim_off(trim_off), .tune_mode(tune_mode), .tick_100hz(tick_100hz), .tune_wave(tune_wave));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: inputs driven at negedge, outputs compared at the next negedge
  task automatic cyc(input bit tk);
    bit surv, done;
    int lat_used;
    osc_tick = tk;
    surv = 0; done = 0; lat_used = m_lat;
    exp_wave = tune_mode && (m_acc < MOD / 5);
    if (tk) begin
      if (m_pos == 0) m_lat = int'(trim_val);
      lat_used = m_lat;
      surv = trim_off || !(m_pos < m_lat);
      m_pos = (m_pos + 1) % W;
      done = (m_pos == 0);
    end
    exp_stb = surv && (m_acc + STEP >= MOD);
    if (surv) begin
      m_acc = (m_acc + STEP) % MOD;
      cum++;
    end
    @(negedge clk);
    chk(tick_100hz == exp_stb, "R3/R6 strobe", tick_100hz, exp_stb);
    chk(tune_wave == exp_wave, "R8 tune_wave", tune_wave, exp_wave);
    if (tick_100hz) win_obs++;
    if (done) begin
      // arithmetic window total: survivors = W minus the head count
      longint s1, want;
      s1 = win_start + W - (trim_off ? 0 : lat_used);
      want = (s1 * STEP) / MOD - (win_start * STEP) / MOD;
      chk(longint'(win_obs) == want, "R2/R3/R5 window strobes", win_obs, want);
      win_start = s1;
      win_obs = 0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    osc_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk(tick_100hz == 1'b0, "R1 reset strobe", tick_100hz, 0);
    chk(tune_wave == 1'b0, "R1 reset wave", tune_wave, 0);
    rst = 1'b0;
    m_pos = 0; m_lat = 0; m_acc = 0; cum = 0; win_start = 0; win_obs = 0;
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // every trim value; the next value is loaded mid-window (R5)
    trim_val = '0;
    for (int w = 0; w < 256; w++) begin
      tune_mode = w[0];
      for (int k = 0; k < W; k++) begin
        if (k == 150) trim_val = TW'(((w + 1) * 37) % 256);
        cyc(1'b1);
      end
    end
    // R4: removal off even at the largest trim value
    trim_off = 1'b1;
    trim_val = 8'd255;
    tune_mode = 1'b1;
    for (int k = 0; k < 2 * W; k++) cyc(1'b1);
    // sparse oscillator enables; window counts enables only (R2)
    trim_off = 1'b0;
    trim_val = 8'd210;
    for (int k = 0; k < 3 * 2 * W; k++) cyc(k % 3 == 0);
    // R1: reset in the middle of a run
    for (int k = 0; k < 37; k++) cyc(1'b1);
    do_reset();
    trim_val = 8'd5;
    for (int k = 0; k < W; k++) cyc(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule